// File: doc/BRIEF.md
# Masked Packed Signed Minimum Unit

This block is a vector datapath stage that takes two source vectors of up to 512 bits, cuts them into signed lanes of 8 or 16 bits and produces, lane by lane, the smaller of each pair. The smaller value is the first source lane when that lane is strictly less than the second source lane. Otherwise it is the second source lane. The old destination value is an input, so the unit can carry unchanged bits through to the new destination.

Three operating styles are supported:

- **Destructive:** the old destination acts as the first source. Only the lowest 128 bits are computed, and the rest of the destination is carried over unchanged.
- **Non-destructive:** the unit computes over the selected vector length and clears every bit above it.
- **Masked:** a per-lane writemask is added. It leaves lanes untouched (merge) or clears them (zero), and everything above the vector length is cleared.

Operands are taken on a cycle where `in_valid` is high. The full-width result is registered and shown one clock later together with `out_valid`.

Top module: `vmin_packed_top`

## Requirements
- R1: Each active lane result is the lane pair's minimum under two's-complement signed comparison. The first operand lane is chosen only when it is strictly less than the second; otherwise the second is chosen. For example, byte 0x80 versus 0x7F gives 0x80.
- R2: `elem_h` = 0 selects 8-bit lanes and `elem_h` = 1 selects 16-bit lanes. Lane j occupies bits [8j+7:8j] or [16j+15:16j] respectively.
- R3: `vlen_sel` sets the active length: 0 means 128 bits, 1 means 256 bits, and 2 or 3 mean 512 bits. This gives 16/32/64 byte lanes or 8/16/32 halfword lanes.
- R4: With `enc_sel` = 0 (destructive), the first operand is `dst_old` and `src_a` is ignored. The active length is 128 bits whatever `vlen_sel` says, and bits above 128 equal `dst_old`.
- R5: With `enc_sel` = 1 or 3 (non-destructive), every lane below the active length is computed from `src_a` and `src_b`. All bits above the active length are zero, and `wmask`, `mask_en` and `zero_mode` have no effect.
- R6: With `enc_sel` = 2 (masked), lane j is computed when `mask_en` = 0, or when `mask_en` = 1 and `wmask[j]` = 1.
- R7: In masked mode with `mask_en` = 1, a lane whose mask bit is 0 keeps its `dst_old` value when `zero_mode` = 0 and is zero when `zero_mode` = 1.
- R8: In masked mode, bits above the active length are zero regardless of the mask.
- R9: Mask bits at or above the lane count of the active length have no effect.
- R10: `out_valid` equals `in_valid` of the previous cycle. A synchronous active-low reset clears `out_valid` and `dst_new` to zero.
- R11: `dst_new` keeps its value across cycles where `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and controls are taken this cycle |
| elem_h | input | 1 | Lane size: 0 byte, 1 halfword |
| vlen_sel | input | 2 | Active vector length code |
| enc_sel | input | 2 | Operating style: 0 destructive, 1/3 non-destructive, 2 masked |
| mask_en | input | 1 | Masked style: apply `wmask` |
| zero_mode | input | 1 | Masked style: 1 clears masked-off lanes, 0 keeps them |
| wmask | input | 64 | Per-lane writemask, bit j for lane j |
| src_a | input | 512 | First source vector (non-destructive and masked styles) |
| src_b | input | 512 | Second source vector |
| dst_old | input | 512 | Previous destination value |
| out_valid | output | 1 | Result valid |
| dst_new | output | 512 | Registered result vector |

## Verification
The bench sweeps every signed byte pair, so a design that compared unsigned values, or picked the wrong operand, would fail the 0x80 against 0x7F lanes. Halfword boundary pairs are also checked, which catches a comparator that splits a halfword into two byte decisions. Every combination of lane size, length code, operating style, mask enable and mask mode is run with random data against an arithmetic model. A design that mixed up the keep-versus-clear rule above the active length, or merge versus zero masking, would show stale or cleared upper bits. Directed cases place all-ones mask bits beyond the lane count and use the reserved length and style codes, which exposes mask indexing that ignores the lane size or a length decode that falls back to 128 bits.

// File: rtl/vmin_pkg.sv
// Package: shared codes and types for the packed signed minimum unit.
// Assumes the operating-style codes below are used at the top ports.
package vmin_pkg;

    localparam logic [1:0] ENC_DESTR  = 2'd0;
    localparam logic [1:0] ENC_NONDES = 2'd1;
    localparam logic [1:0] ENC_MASKED = 2'd2;

    // Per-byte selection of the final destination source.
    typedef enum logic [1:0] {
        BSEL_RESULT = 2'd0,
        BSEL_KEEP   = 2'd1,
        BSEL_ZERO   = 2'd2
    } bsel_e;

endpackage

// File: rtl/vmin_elem_min.sv
// Module: signed minimum of one lane pair.
// Picks a only when a is strictly less than b as two's-complement values.
// Assumes EW >= 2.
module vmin_elem_min #(
    parameter int EW = 8
) (
    input  logic [EW-1:0] a,
    input  logic [EW-1:0] b,
    output logic [EW-1:0] y
);

    // Signed compare and select.
    always_comb begin
        y = ($signed(a) < $signed(b)) ? a : b;
    end

endmodule

// File: rtl/vmin_byte_ctrl.sv
// Module: per-byte destination selection decoder.
// For every byte of the vector it decides whether the byte takes the computed
// minimum, keeps the old destination, or is cleared. Covers active length,
// operating style and writemask. Assumes NBYTE == 4 * BASE_BYTES.
module vmin_byte_ctrl
    import vmin_pkg::*;
#(
    parameter int NBYTE      = 64,
    parameter int BASE_BYTES = 16
) (
    input  logic                    elem_h,
    input  logic [1:0]              vlen_sel,
    input  logic [1:0]              enc_sel,
    input  logic                    mask_en,
    input  logic                    zero_mode,
    input  logic [NBYTE-1:0]        wmask,
    output bsel_e [NBYTE-1:0]       sel
);

    localparam int CW = $clog2(NBYTE) + 1;

    logic [CW-1:0] vl_bytes;
    logic          destr;
    logic          masking;

    // Decode the style and the active length in bytes.
    always_comb begin
        destr   = (enc_sel == ENC_DESTR);
        masking = (enc_sel == ENC_MASKED) && mask_en;
        if (destr) begin
            vl_bytes = CW'(BASE_BYTES);
        end else begin
            case (vlen_sel)
                2'd0:    vl_bytes = CW'(BASE_BYTES);
                2'd1:    vl_bytes = CW'(2 * BASE_BYTES);
                default: vl_bytes = CW'(4 * BASE_BYTES);
            endcase
        end
    end

    for (genvar k = 0; k < NBYTE; k++) begin : g_byte
        logic mbit;
        // Mask bit of the lane that owns this byte.
        assign mbit = elem_h ? wmask[k/2] : wmask[k];

        // Choose the byte source from range, style and mask.
        always_comb begin
            if (!(vl_bytes > CW'(k))) begin
                sel[k] = destr ? BSEL_KEEP : BSEL_ZERO;
            end else if (masking && !mbit) begin
                sel[k] = zero_mode ? BSEL_ZERO : BSEL_KEEP;
            end else begin
                sel[k] = BSEL_RESULT;
            end
        end
    end

endmodule

// File: rtl/vmin_packed_top.sv
// Module: masked packed signed minimum unit, top level.
// Computes byte-lane and halfword-lane minima in parallel, selects by lane
// size, merges with the old destination per byte and registers the result.
// Assumes VMAX_BITS == 4 * BASE_BITS and both are multiples of 16.
module vmin_packed_top
    import vmin_pkg::*;
#(
    parameter int VMAX_BITS = 512,
    parameter int BASE_BITS = 128
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   elem_h,
    input  logic [1:0]             vlen_sel,
    input  logic [1:0]             enc_sel,
    input  logic                   mask_en,
    input  logic                   zero_mode,
    input  logic [VMAX_BITS/8-1:0] wmask,
    input  logic [VMAX_BITS-1:0]   src_a,
    input  logic [VMAX_BITS-1:0]   src_b,
    input  logic [VMAX_BITS-1:0]   dst_old,
    output logic                   out_valid,
    output logic [VMAX_BITS-1:0]   dst_new
);

    localparam int NBYTE      = VMAX_BITS / 8;
    localparam int NHALF      = VMAX_BITS / 16;
    localparam int BASE_BYTES = BASE_BITS / 8;

    logic [VMAX_BITS-1:0] op_a;
    logic [VMAX_BITS-1:0] min_b8;
    logic [VMAX_BITS-1:0] min_h16;
    logic [VMAX_BITS-1:0] min_sel;
    logic [VMAX_BITS-1:0] nxt;
    bsel_e [NBYTE-1:0]    sel;

    // First operand: old destination in the destructive style.
    always_comb begin
        op_a = (enc_sel == ENC_DESTR) ? dst_old : src_a;
    end

    for (genvar i = 0; i < NBYTE; i++) begin : g_b8
        vmin_elem_min #(.EW(8)) u_min (
            .a (op_a[i*8 +: 8]),
            .b (src_b[i*8 +: 8]),
            .y (min_b8[i*8 +: 8])
        );
    end

    for (genvar i = 0; i < NHALF; i++) begin : g_h16
        vmin_elem_min #(.EW(16)) u_min (
            .a (op_a[i*16 +: 16]),
            .b (src_b[i*16 +: 16]),
            .y (min_h16[i*16 +: 16])
        );
    end

    // Pick the lane-size variant of the minima.
    always_comb begin
        min_sel = elem_h ? min_h16 : min_b8;
    end

    vmin_byte_ctrl #(
        .NBYTE      (NBYTE),
        .BASE_BYTES (BASE_BYTES)
    ) u_ctrl (
        .elem_h    (elem_h),
        .vlen_sel  (vlen_sel),
        .enc_sel   (enc_sel),
        .mask_en   (mask_en),
        .zero_mode (zero_mode),
        .wmask     (wmask),
        .sel       (sel)
    );

    for (genvar k = 0; k < NBYTE; k++) begin : g_merge
        // Per-byte merge of result, old value or zero.
        always_comb begin
            case (sel[k])
                BSEL_RESULT: nxt[k*8 +: 8] = min_sel[k*8 +: 8];
                BSEL_KEEP:   nxt[k*8 +: 8] = dst_old[k*8 +: 8];
                default:     nxt[k*8 +: 8] = 8'h00;
            endcase
        end
    end

    // Output register with valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            dst_new   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                dst_new <= nxt;
            end
        end
    end

    // R10: valid follows the previous cycle's in_valid.
    p_valid_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R11: result register holds while idle.
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(dst_new));

    // R4: destructive style carries the upper destination bits.
    p_destr_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && enc_sel == ENC_DESTR)
        |=> dst_new[VMAX_BITS-1:BASE_BITS] == $past(dst_old[VMAX_BITS-1:BASE_BITS]));

    // R5: non-destructive style at base length clears the upper bits.
    p_nondes_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && enc_sel[0] && vlen_sel == 2'd0)
        |=> dst_new[VMAX_BITS-1:BASE_BITS] == '0);

    // R8: masked style at base length clears the upper bits.
    p_masked_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && enc_sel == ENC_MASKED && vlen_sel == 2'd0)
        |=> dst_new[VMAX_BITS-1:BASE_BITS] == '0);

    // R7: zero masking with an empty mask clears the whole vector.
    p_zero_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && enc_sel == ENC_MASKED && mask_en && zero_mode && wmask == '0)
        |=> dst_new == '0);

endmodule

// File: tb/vmin_packed_top_tb.sv
module vmin_packed_top_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         elem_h = 1'b0;
    logic [1:0]   vlen_sel = 2'd0;
    logic [1:0]   enc_sel = 2'd0;
    logic         mask_en = 1'b0;
    logic         zero_mode = 1'b0;
    logic [63:0]  wmask = '0;
    logic [511:0] src_a = '0;
    logic [511:0] src_b = '0;
    logic [511:0] dst_old = '0;
    logic         out_valid;
    logic [511:0] dst_new;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    vmin_packed_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .elem_h    (elem_h),
        .vlen_sel  (vlen_sel),
        .enc_sel   (enc_sel),
        .mask_en   (mask_en),
        .zero_mode (zero_mode),
        .wmask     (wmask),
        .src_a     (src_a),
        .src_b     (src_b),
        .dst_old   (dst_old),
        .out_valid (out_valid),
        .dst_new   (dst_new)
    );

    function automatic logic [511:0] rnd512();
        logic [511:0] v;
        for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    // Arithmetic reference built from the requirements.
    function automatic logic [511:0] model(
        input logic esz, input logic [1:0] vl, input logic [1:0] enc,
        input logic men, input logic zm, input logic [63:0] wm,
        input logic [511:0] a, input logic [511:0] b, input logic [511:0] old);
        int nb;
        int ne;
        logic [511:0] r;
        logic [511:0] first;
        nb    = (enc == 2'd0) ? 16 : (vl == 2'd0) ? 16 : (vl == 2'd1) ? 32 : 64;
        ne    = esz ? nb / 2 : nb;
        r     = (enc == 2'd0) ? old : '0;
        first = (enc == 2'd0) ? old : a;
        for (int j = 0; j < ne; j++) begin
            bit act;
            act = !(enc == 2'd2 && men && !wm[j]);
            if (!esz) begin
                logic signed [7:0] x;
                logic signed [7:0] y;
                x = first[j*8 +: 8];
                y = b[j*8 +: 8];
                r[j*8 +: 8] = act ? ((x < y) ? x : y) : (zm ? 8'h00 : old[j*8 +: 8]);
            end else begin
                logic signed [15:0] x;
                logic signed [15:0] y;
                x = first[j*16 +: 16];
                y = b[j*16 +: 16];
                r[j*16 +: 16] = act ? ((x < y) ? x : y) : (zm ? 16'h0000 : old[j*16 +: 16]);
            end
        end
        return r;
    endfunction

    // Drive one operation, then check the registered result.
    task automatic run_op(input string tag);
        logic [511:0] exp;
        exp = model(elem_h, vlen_sel, enc_sel, mask_en, zero_mode, wmask, src_a, src_b, dst_old);
        @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        n_tests++;
        if (!out_valid || dst_new !== exp) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b %h expected valid=1 %h", tag, out_valid, dst_new, exp);
        end
    endtask

    task automatic set_cfg(input logic e, input logic [1:0] v, input logic [1:0] s,
                           input logic m, input logic z);
        elem_h = e; vlen_sel = v; enc_sel = s; mask_en = m; zero_mode = z;
    endtask

    initial begin
        #(10 * 200000);
        n_fail++;
        $display("FAIL watchdog: got hang expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [511:0] held;
        string        tg;
        repeat (3) @(negedge clk);
        // R10: reset state.
        n_tests++;
        if (out_valid !== 1'b0 || dst_new !== '0) begin
            n_fail++;
            $display("FAIL R10 reset: got %0b %h expected 0 0", out_valid, dst_new);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R1: every signed byte pair, 64 pairs per vector.
        set_cfg(1'b0, 2'd2, 2'd1, 1'b0, 1'b0);
        wmask = '0;
        for (int v = 0; v < 1024; v++) begin
            for (int e = 0; e < 64; e++) begin
                logic [15:0] p;
                p = 16'(v * 64 + e);
                src_a[e*8 +: 8] = p[15:8];
                src_b[e*8 +: 8] = p[7:0];
            end
            dst_old = rnd512();
            run_op("R1");
        end

        // R1/R2: halfword extremes, pairs across all lanes.
        set_cfg(1'b1, 2'd2, 2'd1, 1'b0, 1'b0);
        for (int v = 0; v < 4; v++) begin
            for (int e = 0; e < 32; e++) begin
                logic [15:0] ev [0:6];
                int idx;
                ev[0] = 16'h8000; ev[1] = 16'h7FFF; ev[2] = 16'hFFFF; ev[3] = 16'h0000;
                ev[4] = 16'h0001; ev[5] = 16'h8001; ev[6] = 16'h7FFE;
                idx = v * 32 + e;
                src_a[e*16 +: 16] = ev[(idx / 7) % 7];
                src_b[e*16 +: 16] = ev[idx % 7];
            end
            run_op("R2");
        end

        // R2: byte-versus-halfword split on the same data (0x80FF vs 0x7F00).
        for (int e = 0; e < 32; e++) begin
            src_a[e*16 +: 16] = 16'h80FF;
            src_b[e*16 +: 16] = 16'h7F00;
        end
        set_cfg(1'b1, 2'd2, 2'd1, 1'b0, 1'b0); run_op("R2");
        set_cfg(1'b0, 2'd2, 2'd1, 1'b0, 1'b0); run_op("R2");

        // Full configuration sweep with random data.
        for (int c = 0; c < 128; c++) begin
            for (int rep = 0; rep < 4; rep++) begin
                logic [6:0] cb;
                cb = 7'(c);
                set_cfg(cb[0], cb[2:1], cb[4:3], cb[5], cb[6]);
                src_a = rnd512(); src_b = rnd512(); dst_old = rnd512();
                wmask = {$urandom, $urandom};
                if (enc_sel == 2'd0)      tg = "R4";
                else if (enc_sel != 2'd2) tg = "R5";
                else if (!mask_en)        tg = "R6";
                else                      tg = "R7";
                run_op(tg);
            end
        end

        // R3: reserved length code acts as 512 bits.
        set_cfg(1'b0, 2'd3, 2'd1, 1'b0, 1'b0);
        src_a = rnd512(); src_b = rnd512(); dst_old = rnd512();
        run_op("R3");
        set_cfg(1'b1, 2'd1, 2'd3, 1'b1, 1'b1);
        wmask = '0;
        run_op("R3");

        // R4: src_a ignored in destructive style.
        set_cfg(1'b0, 2'd2, 2'd0, 1'b0, 1'b0);
        src_a = '1; src_b = rnd512(); dst_old = rnd512();
        run_op("R4");

        // R8: merge masking, empty mask, base length.
        set_cfg(1'b0, 2'd0, 2'd2, 1'b1, 1'b0);
        wmask = '0; dst_old = '1;
        run_op("R8");

        // R9: mask bits beyond 8 halfword lanes have no effect.
        set_cfg(1'b1, 2'd0, 2'd2, 1'b1, 1'b0);
        wmask = 64'hFFFF_FFFF_FFFF_FF00;
        src_a = rnd512(); src_b = rnd512(); dst_old = rnd512();
        run_op("R9");
        set_cfg(1'b0, 2'd1, 2'd2, 1'b1, 1'b1);
        wmask = 64'hFFFF_FFFF_0000_0005;
        run_op("R9");

        // R6: single lane enabled.
        set_cfg(1'b1, 2'd2, 2'd2, 1'b1, 1'b1);
        wmask = 64'h0000_0000_8000_0000;
        run_op("R6");

        // R11: result holds while idle; R10: valid drops.
        held = dst_new;
        src_a = rnd512(); src_b = rnd512(); dst_old = rnd512();
        set_cfg(1'b0, 2'd2, 2'd1, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        n_tests++;
        if (dst_new !== held || out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R11: got %0b %h expected 0 %h", out_valid, dst_new, held);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule